// File: doc/BRIEF.md
# Oversampled Bit-Stream Decimator with Channel-Switch Settling

This block turns the single-bit output of a first-order delta-sigma modulator into multi-bit samples. The incoming stream is clocked at the modulator rate and qualified by a valid strobe. A third-order cascaded integrator-comb (CIC) low-pass filter removes content above half the output rate. One output sample is kept for every 128 accepted bits. Each bit counts as 1 when high and 0 when low. The filter's DC gain is 2^21, so a fully settled raw result lies in the range 0 to 2^21. The block centres and scales that result into a 16-bit two's-complement code, saturating at the top end.

Upstream logic raises a channel-change pulse whenever the analog input multiplexer or range setting is switched. That pulse restarts the decimation phase. The block then withholds its next three output samples, one per filter stage, because those samples still mix data from before the switch. With the fourth sample the output is valid again and a settled flag goes high. Software or a downstream consumer never has to count samples itself after a switch.

Top module: `sdd_decimator`

## Requirements
- R1: While reset is held and directly after it, `sample_valid` is 0, `settled` is 0 and `sample` is 0.
- R2: Only bits with `bit_valid` high and `chan_change` low are accepted. Exactly one `sample_valid` pulse is produced per 128 accepted bits, one clock after the 128th. Cycles with `bit_valid` low affect neither phase nor data.
- R3: Each valid sample equals s = floor((y - 2^20) / 32), clipped to 32767. Here y = sum over k of h[k]*x[m-k], with x being the accepted bits as 0/1 and x[m] the newest. The weights h are the 382-tap convolution of three 128-long boxcars. This holds over arbitrarily long runs, although the internal 22-bit registers wrap.
- R4: A constant all-ones stream settles to 32767 (0x7FFF). A constant all-zeros stream settles to -32768 (0x8000).
- R5: A `chan_change` pulse restarts the phase count. The first decimation point after it comes with the 128th bit accepted after the pulse. A bit presented in the pulse cycle is discarded.
- R6: After reset or a `chan_change` pulse, the first three decimation points produce no `sample_valid`, and `settled` stays 0 through them.
- R7: `settled` goes to 1 in the same cycle as the first `sample_valid` after suppression. It stays 1 until a `chan_change` pulse, and it reads 0 in the cycle after that pulse.
- R8: `sample` keeps its value in every cycle in which `sample_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Modulator output bit (1 = high reference) |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| chan_change | input | 1 | Single-cycle pulse on input or range switch |
| sample | output | 16 | Decimated two's-complement sample |
| sample_valid | output | 1 | One-cycle strobe for a new `sample` |
| settled | output | 1 | High once output reflects only post-switch data |

## Verification
The hardest case to reach is a channel switch that lands in the middle of a decimation period while the integrators have already wrapped. In that case only the phase restart keeps the old comb history from corrupting the fourth sample. The stimulus first runs a long varying-level modulator stream and sends a partial period of bits. It then pulses the switch with a live bit in that cycle, which must be discarded, and continues with gapped input. The reference recomputes every expected sample from the accepted bit history through the explicit 382-tap weight set, rather than through integrators and combs.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
   // Default configuration of the decimator
   localparam int SDD_ORDER  = 3;   // CIC stages
   localparam int SDD_LOG2_R = 7;   // decimation ratio 2**7 = 128
   localparam int SDD_OUT_W  = 16;  // output sample width

   // Register width needed for a unipolar 1-bit input: order*log2(R) + 1
   function automatic int sdd_acc_width(input int order, input int log2r);
      return order * log2r + 1;
   endfunction
endpackage

// File: rtl/sdd_integ_chain.sv
module sdd_integ_chain #(
   parameter int ORDER = 3,
   parameter int ACC_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             din,
   output logic [ACC_W-1:0] sum_next
);
   // stage_in[g] feeds integrator g; stage_in[ORDER] is the newest chain output
   logic [ACC_W-1:0] stage_in [0:ORDER];

   assign stage_in[0] = {{(ACC_W-1){1'b0}}, din};

   for (genvar g = 0; g < ORDER; g++) begin : gen_integ
      logic [ACC_W-1:0] acc_q;
      assign stage_in[g+1] = acc_q + stage_in[g];   // wrap-around add
      always_ff @(posedge clk) begin
         if (!rst_n)  acc_q <= '0;
         else if (en) acc_q <= stage_in[g+1];
      end
   end

   assign sum_next = stage_in[ORDER];
endmodule

// File: rtl/sdd_comb_chain.sv
module sdd_comb_chain #(
   parameter int ORDER = 3,
   parameter int ACC_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [ACC_W-1:0] din,
   output logic [ACC_W-1:0] dout
);
   logic [ACC_W-1:0] stage [0:ORDER];

   assign stage[0] = din;

   for (genvar g = 0; g < ORDER; g++) begin : gen_comb
      logic [ACC_W-1:0] dly_q;
      assign stage[g+1] = stage[g] - dly_q;         // wrap-around difference
      always_ff @(posedge clk) begin
         if (!rst_n)  dly_q <= '0;
         else if (en) dly_q <= stage[g];
      end
   end

   assign dout = stage[ORDER];
endmodule

// File: rtl/sdd_settle_ctrl.sv
module sdd_settle_ctrl #(
   parameter int LOG2_R = 7,
   parameter int ORDER  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic chan_change,
   output logic accept,
   output logic dec_strobe,
   output logic emit,
   output logic out_valid,
   output logic settled
);
   localparam int SKW = $clog2(ORDER + 1);
   localparam logic [SKW-1:0] SKIP_INIT = SKW'(ORDER);

   logic [LOG2_R-1:0] phase_q;
   logic [SKW-1:0]    skip_q;
   logic              out_valid_q;
   logic              settled_q;

   assign accept     = bit_valid & ~chan_change;
   assign dec_strobe = accept & (&phase_q);
   assign emit       = dec_strobe & (skip_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= '0;
         skip_q      <= SKIP_INIT;
         out_valid_q <= 1'b0;
         settled_q   <= 1'b0;
      end else begin
         out_valid_q <= emit;
         if (chan_change) begin
            phase_q   <= '0;
            skip_q    <= SKIP_INIT;
            settled_q <= 1'b0;
         end else if (accept) begin
            phase_q <= phase_q + 1'b1;
            if (dec_strobe) begin
               if (skip_q != '0) skip_q    <= skip_q - 1'b1;
               else              settled_q <= 1'b1;
            end
         end
      end
   end

   assign out_valid = out_valid_q;
   assign settled   = settled_q;

   AST_CHANGE_CLEARS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      chan_change |=> !settled_q);  // R7
   AST_VALID_IMPLIES_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_q |-> settled_q);  // R7
   AST_CHANGE_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
      chan_change |=> !out_valid_q);  // R6
   AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      chan_change |=> (phase_q == '0));  // R5
   AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_q |-> $past(bit_valid && !chan_change));  // R2
endmodule

// File: rtl/sdd_decimator.sv
module sdd_decimator import sdd_pkg::*; #(
   parameter int ORDER  = SDD_ORDER,
   parameter int LOG2_R = SDD_LOG2_R,
   parameter int OUT_W  = SDD_OUT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_in,
   input  logic             bit_valid,
   input  logic             chan_change,
   output logic [OUT_W-1:0] sample,
   output logic             sample_valid,
   output logic             settled
);
   localparam int ACC_W = sdd_acc_width(ORDER, LOG2_R);
   localparam int SH    = ACC_W - 1 - OUT_W;
   // Mid-scale of the unipolar raw result: 2**(ACC_W-2)
   localparam logic [ACC_W:0] OFFSET = {2'b00, 1'b1, {(ACC_W-2){1'b0}}};
   localparam logic signed [ACC_W:0] MAXV = {{(ACC_W+2-OUT_W){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W:0] MINV = {{(ACC_W+2-OUT_W){1'b1}}, {(OUT_W-1){1'b0}}};

   initial begin : elab_checks
      AST_ORDER_RANGE: assert (ORDER >= 1) else $error("ORDER must be at least 1");
      AST_RATIO_RANGE: assert (LOG2_R >= 1) else $error("LOG2_R must be at least 1");
      AST_OUT_FITS: assert (OUT_W >= 2 && OUT_W <= ACC_W - 1)
         else $error("OUT_W must lie in 2..ACC_W-1");
   end

   logic             accept, dec_strobe, emit, out_valid, settled_w;
   logic [ACC_W-1:0] integ_out, comb_out;
   logic signed [ACC_W:0] centered, scaled;
   logic [OUT_W-1:0] clipped;
   logic [OUT_W-1:0] sample_q;

   sdd_settle_ctrl #(.LOG2_R(LOG2_R), .ORDER(ORDER)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_valid  (bit_valid),
      .chan_change(chan_change),
      .accept     (accept),
      .dec_strobe (dec_strobe),
      .emit       (emit),
      .out_valid  (out_valid),
      .settled    (settled_w)
   );

   sdd_integ_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (accept),
      .din     (bit_in),
      .sum_next(integ_out)
   );

   sdd_comb_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (dec_strobe),
      .din  (integ_out),
      .dout (comb_out)
   );

   // Centre the unipolar result around zero
   assign centered = $signed({1'b0, comb_out}) - $signed(OFFSET);

   if (SH > 0) begin : gen_shift
      assign scaled = centered >>> SH;
   end else begin : gen_noshift
      assign scaled = centered;
   end

   always_comb begin
      if (scaled > MAXV)      clipped = MAXV[OUT_W-1:0];
      else if (scaled < MINV) clipped = MINV[OUT_W-1:0];
      else                    clipped = scaled[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    sample_q <= '0;
      else if (emit) sample_q <= clipped;
   end

   assign sample       = sample_q;
   assign sample_valid = out_valid;
   assign settled      = settled_w;

   AST_SAMPLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |-> $stable(sample));  // R8
   AST_SETTLED_NO_EARLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled) |-> sample_valid);  // R7
endmodule

// File: tb/tb_sdd_decimator.sv
`timescale 1ns/1ps
module tb_sdd_decimator;
   localparam int R      = 128;
   localparam int NTAP   = 3 * R - 2;
   localparam int TIMEOUT = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_in = 1'b0;
   logic        bit_valid = 1'b0;
   logic        chan_change = 1'b0;
   logic [15:0] sample;
   logic        sample_valid;
   logic        settled;

   always #4 clk = ~clk;   // 125 MHz

   sdd_decimator dut (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
      .chan_change(chan_change), .sample(sample), .sample_valid(sample_valid),
      .settled(settled)
   );

   int    checks = 0;
   int    failures = 0;
   int    h [0:NTAP-1];
   bit    xr [0:511];
   int    wpos = 0;
   int    cnt = 0;
   int    ndec = 0;
   int    mod_acc = 0;
   int    exp_q [$];
   string tag_q [$];
   string cur_tag = "R3";
   int    pushed = 0;
   int    seen = 0;
   int    hold_viol = 0;
   logic [15:0] prev_sample = 16'h0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int model_expect();
      int y = 0;
      int s;
      for (int k = 0; k < NTAP; k++)
         y += h[k] * int'(xr[(wpos - 1 - k) & 511]);
      s = (y - 1048576) >>> 5;
      if (s > 32767) s = 32767;
      return s;
   endfunction

   function automatic bit mod_next(input int level);
      mod_acc += level;
      if (mod_acc >= 1024) begin
         mod_acc -= 1024;
         return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic model_accept(input bit b);
      xr[wpos] = b;
      wpos = (wpos + 1) & 511;
      cnt++;
      if (cnt % R == 0) begin
         ndec++;
         if (ndec > 3) begin
            exp_q.push_back(model_expect());
            tag_q.push_back(cur_tag);
            pushed++;
         end
      end
   endtask

   task automatic send(input bit b);
      @(negedge clk);
      bit_in = b; bit_valid = 1'b1; chan_change = 1'b0;
      model_accept(b);
   endtask

   task automatic gap(input bit junk);
      @(negedge clk);
      bit_in = junk; bit_valid = 1'b0; chan_change = 1'b0;
   endtask

   task automatic change(input bit b, input bit v);
      @(negedge clk);
      bit_in = b; bit_valid = v; chan_change = 1'b1;
      cnt = 0; ndec = 0;
   endtask

   // Scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (sample_valid) begin
               seen++;
               chk("R7 settled with valid", int'(settled), 1);
               if (exp_q.size() == 0) begin
                  checks++; failures++;
                  $display("FAIL R6 unexpected sample_valid actual=1 expected=0");
               end else begin
                  string t;
                  int e;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  chk(t, int'($signed(sample)), e);
               end
            end else if (sample != prev_sample) begin
               hold_viol++;
            end
            prev_sample = sample;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (TIMEOUT) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
   end

   initial begin
      int b2 [0:2*R-2];
      for (int k = 0; k <= 2*R-2; k++) b2[k] = (k < R) ? k + 1 : 2*R - 1 - k;
      for (int k = 0; k < NTAP; k++) begin
         h[k] = 0;
         for (int j = 0; j < R; j++)
            if (k - j >= 0 && k - j <= 2*R-2) h[k] += b2[k-j];
      end
      for (int i = 0; i < 512; i++) xr[i] = 1'b0;

      // R1: reset state
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R1 sample_valid in reset", int'(sample_valid), 0);
      chk("R1 settled in reset", int'(settled), 0);
      chk("R1 sample in reset", int'(sample), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 settled after reset", int'(settled), 0);

      // R3: mid-level stream from reset
      cur_tag = "R3 mid level";
      for (int i = 0; i < 8 * R; i++) send(mod_next(512));
      gap(1'b0);
      chk("R7 settled after reset run", int'(settled), 1);

      // R5/R7: switch with live bit that must be discarded, then all ones
      change(1'b1, 1'b1);
      gap(1'b0);
      chk("R7 settled drops after change", int'(settled), 0);
      cur_tag = "R4 all ones";
      for (int i = 0; i < 4 * R - 1; i++) send(1'b1);
      gap(1'b0);
      chk("R5 no settle before 512th bit", int'(settled), 0);
      send(1'b1);
      gap(1'b0);
      chk("R5 settled at 512th bit", int'(settled), 1);
      chk("R4 positive full scale", int'($signed(sample)), 32767);
      for (int i = 0; i < 2 * R; i++) send(1'b1);

      // R2/R5: mid-period switch, zeros with gaps carrying junk ones
      for (int i = 0; i < 50; i++) send(1'b1);
      change(1'b1, 1'b1);
      cur_tag = "R4 all zeros";
      for (int i = 0; i < 4 * R - 1; i++) begin
         send(1'b0);
         if (i % 3 == 0) gap(1'b1);
      end
      gap(1'b1);
      chk("R2 gaps do not advance phase", int'(settled), 0);
      send(1'b0);
      gap(1'b1);
      chk("R2 settled after 512 accepted", int'(settled), 1);
      chk("R4 negative full scale", int'($signed(sample)), -32768);

      // R3: long varying-level run, integrators wrap
      cur_tag = "R3 varying level";
      for (int p = 0; p < 40; p++) begin
         for (int i = 0; i < R; i++) begin
            send(mod_next(64 + (p * 97) % 900));
            if (i % 7 == 3) gap(1'b1);
         end
      end

      // R6: suppression window after a switch
      for (int i = 0; i < 37; i++) send(mod_next(300));
      change(1'b0, 1'b0);
      cur_tag = "R3 after switch";
      for (int i = 0; i < 3 * R; i++) send(mod_next(700));
      gap(1'b0);
      chk("R6 settled low through 3 decimations", int'(settled), 0);
      for (int i = 0; i < 2 * R; i++) send(mod_next(700));
      gap(1'b0);
      chk("R7 settled after suppression", int'(settled), 1);

      repeat (4) gap(1'b0);
      chk("R2 all expected samples produced", exp_q.size(), 0);
      chk("R2 valid count", seen, pushed);
      chk("R8 sample held between valids", hold_viol, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule